// File: doc/BRIEF.md
# Dual-Bank Paired Register File

This block holds eight 8-bit registers in two banks of four. The low bank covers R0–R3 and the high bank covers R4–R7. The bank index fields come straight from bits of the current instruction. Each bank has its own two-bit field, so one instruction reaches at most one register per bank. Two registers in the same bank cannot be used together. Software handles that case by keeping one register as scratch and copying a value into the opposite bank first.

The bus controller gives each bank two strobes. One makes the bank drive the shared data bus. The other makes it load from the bus on the next rising clock edge. Each bank decodes its read index and its write index separately, so a bank can be read at one entry and written at another in the same cycle.

The shared bus is modelled as a multiplexer with an output-enable, not as a tri-state net. When no bank is driving, the file puts zero on the bus and drops the enable. A register-to-register move takes one cycle: one bank drives the bus, the surrounding logic loops the bus back to `bus_in`, and the other bank loads it.

Top module: `pairbank_regfile`

## Requirements
- R1: While `rst_n` is low, all eight registers clear to zero. After reset, reading any entry returns 0.
- R2: When `lo_load` is high at a rising edge, `bus_in` is stored in low-bank entry `lo_wr_idx`. Index 0..3 selects R0..R3.
- R3: When `hi_load` is high at a rising edge, `bus_in` is stored in high-bank entry `hi_wr_idx`. Index 0..3 selects R4..R7.
- R4: A bank whose load strobe is low keeps all four entries unchanged, whatever `bus_in` and the index fields carry.
- R5: A write into one bank leaves every entry of the other bank unchanged.
- R6: With `lo_drv` high, `bus_out` shows low-bank entry `lo_rd_idx` in the same cycle and `bus_oe` is 1.
- R7: With `hi_drv` high and `lo_drv` low, `bus_out` shows high-bank entry `hi_rd_idx` in the same cycle and `bus_oe` is 1.
- R8: With both drive strobes low, `bus_oe` is 0 and `bus_out` is 0.
- R9: If both drive strobes are high, the low bank takes the bus and `bus_out` shows low-bank entry `lo_rd_idx`.
- R10: When a bank is read and written at the same index in one cycle, `bus_out` shows the old value in that cycle. The new value appears from the next cycle on.
- R11: Both banks may load in the same edge, each at its own write index. A drive from one bank with a load into the other moves a value across banks in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_rd_idx | input | 2 | Low-bank entry placed on the bus |
| lo_wr_idx | input | 2 | Low-bank entry loaded from the bus |
| hi_rd_idx | input | 2 | High-bank entry placed on the bus |
| hi_wr_idx | input | 2 | High-bank entry loaded from the bus |
| lo_drv | input | 1 | Low bank drives the bus |
| hi_drv | input | 1 | High bank drives the bus |
| lo_load | input | 1 | Low bank loads from the bus at the edge |
| hi_load | input | 1 | High bank loads from the bus at the edge |
| bus_in | input | 8 | Bus value offered for loading |
| bus_out | output | 8 | Value the file places on the bus |
| bus_oe | output | 1 | High while some bank drives the bus |

## Verification
Two functions can fall in the same cycle. One is a combinational read of a bank; the other is a clocked write into that same bank or into the other bank. The bench provokes both cases: a read and a write at the same index, and a read and a write at different indices. It also loops `bus_out` back into `bus_in` for cross-bank moves, and ends with a long run of random strobe and index mixes. A behavioural eight-entry model judges every cycle. The bus value must match the model before the edge, which gives the old value. All registers are then read back after the edge to confirm that only the named entry changed.

// File: rtl/pairbank_regfile.sv
module pairbank_regfile #(
  parameter int WIDTH     = 8,
  parameter int BANK_REGS = 4,
  localparam int IDX_W    = $clog2(BANK_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lo_rd_idx,
  input  logic [IDX_W-1:0] lo_wr_idx,
  input  logic [IDX_W-1:0] hi_rd_idx,
  input  logic [IDX_W-1:0] hi_wr_idx,
  input  logic             lo_drv,
  input  logic             hi_drv,
  input  logic             lo_load,
  input  logic             hi_load,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe
);
  localparam int NBANK = 2;

  logic [NBANK-1:0][BANK_REGS-1:0][WIDTH-1:0] bank_q;
  logic [NBANK-1:0][IDX_W-1:0]                rd_idx, wr_idx;
  logic [NBANK-1:0]                           load_v;
  logic [NBANK-1:0][WIDTH-1:0]                rd_val;

  assign rd_idx = {hi_rd_idx, lo_rd_idx};
  assign wr_idx = {hi_wr_idx, lo_wr_idx};
  assign load_v = {hi_load, lo_load};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank_q[b] <= '0;
      else if (load_v[b]) bank_q[b][wr_idx[b]] <= bus_in;
    end

    assign rd_val[b] = bank_q[b][rd_idx[b]];

    // R2 R3
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_v[b] |=> bank_q[b][$past(wr_idx[b])] == $past(bus_in));

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_v[b] |=> $stable(bank_q[b]));
  end

  assign bus_oe  = lo_drv | hi_drv;
  assign bus_out = lo_drv ? rd_val[0] : (hi_drv ? rd_val[1] : '0);

  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_drv && !hi_drv) |-> (bus_out == '0 && !bus_oe));

  // R9
  low_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_drv && hi_drv) |-> (bus_out == bank_q[0][lo_rd_idx]));

  // R5
  cross_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_load && !hi_load) |=> $stable(bank_q[1]));
endmodule

// File: tb/pairbank_regfile_tb.sv
module pairbank_regfile_tb_top;
  logic       clk = 0, rst_n = 0;
  logic [1:0] lo_rd_idx = 0, lo_wr_idx = 0, hi_rd_idx = 0, hi_wr_idx = 0;
  logic       lo_drv = 0, hi_drv = 0, lo_load = 0, hi_load = 0;
  logic [7:0] bus_in = 0;
  logic [7:0] bus_out;
  logic       bus_oe;

  int checks = 0, errors = 0;
  int model [8];

  always #5 clk = ~clk;

  pairbank_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .lo_rd_idx(lo_rd_idx), .lo_wr_idx(lo_wr_idx),
    .hi_rd_idx(hi_rd_idx), .hi_wr_idx(hi_wr_idx),
    .lo_drv(lo_drv), .hi_drv(hi_drv), .lo_load(lo_load), .hi_load(hi_load),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // apply at negedge, judge bus before the edge, advance model at the edge
  task automatic cyc(string tag, bit ld, bit hd, bit ll, bit hl,
                     int lr, int lw, int hr, int hw, int din, bit loop);
    int exp_bus, exp_oe, val;
    lo_drv = ld; hi_drv = hd; lo_load = ll; hi_load = hl;
    lo_rd_idx = 2'(lr); lo_wr_idx = 2'(lw); hi_rd_idx = 2'(hr); hi_wr_idx = 2'(hw);
    exp_oe  = (ld || hd) ? 1 : 0;
    exp_bus = ld ? model[lr] : (hd ? model[4 + hr] : 0);
    val     = loop ? exp_bus : din;
    bus_in  = 8'(val);
    #2;
    check(tag, bus_out, exp_bus);
    check(tag, bus_oe, exp_oe);
    @(posedge clk);
    if (ll) model[lw] = val & 255;
    if (hl) model[4 + hw] = val & 255;
    @(negedge clk);
  endtask

  task automatic readback_all(string tag);
    for (int i = 0; i < 4; i++) cyc(tag, 1, 0, 0, 0, i, 0, 0, 0, 8'hEE, 0);
    for (int i = 0; i < 4; i++) cyc(tag, 0, 1, 0, 0, 0, 0, i, 0, 8'hEE, 0);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset contents
    readback_all("R1");
    // R8 idle bus
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 0, 8'h5A, 0);

    // R2 fill low bank, R3 fill high bank, distinct values
    for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 1, 0, 0, i, 0, 0, 8'h11 * (i + 1), 0);
    for (int i = 0; i < 4; i++) cyc("R3", 0, 0, 0, 1, 0, 0, 0, i, 8'hA0 + i, 0);
    // R6 R7 read back all eight
    readback_all("R6");
    readback_all("R7");

    // R4 strobes low with busy bus and indices
    cyc("R4", 0, 0, 0, 0, 0, 2, 0, 3, 8'hFF, 0);
    readback_all("R4");

    // R5 low writes must not disturb high bank and vice versa
    cyc("R5", 0, 0, 1, 0, 0, 1, 0, 1, 8'h77, 0);
    cyc("R5", 0, 0, 0, 1, 0, 2, 0, 2, 8'h88, 0);
    readback_all("R5");

    // R9 both drivers, low wins
    cyc("R9", 1, 1, 0, 0, 3, 0, 0, 0, 0, 0);
    cyc("R9", 1, 1, 0, 0, 0, 0, 2, 0, 0, 0);

    // R10 read and write same index same bank: old value now, new next
    cyc("R10", 1, 0, 1, 0, 2, 2, 0, 0, 8'h3C, 0);
    cyc("R10", 1, 0, 0, 0, 2, 0, 0, 0, 0, 0);
    cyc("R10", 0, 1, 0, 1, 0, 0, 1, 1, 8'hC3, 0);
    cyc("R10", 0, 1, 0, 0, 0, 0, 1, 0, 0, 0);

    // R11 simultaneous loads at separate indices and cross-bank moves
    cyc("R11", 0, 0, 1, 1, 0, 3, 0, 0, 8'h42, 0);
    cyc("R11", 0, 1, 1, 0, 0, 0, 3, 0, 0, 1);
    cyc("R11", 1, 0, 0, 1, 1, 0, 0, 3, 0, 1);
    readback_all("R11");

    // R11 random mix judged against the model every cycle
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      cyc("R11", r[0], r[1], r[2], r[3], r[5:4], r[7:6], r[9:8], r[11:10],
          r[19:12], r[20]);
    end
    readback_all("R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule